// File: doc/BRIEF.md
# Daisy-Chainable Serial Command Frame Receiver

This block is the serial front end of a single-channel DAC controller. It takes three pins from a host: an active-low select, a serial clock and a data line. It assembles fixed 24-bit command frames, most significant bit first, from the bits sampled on the falling edges of the serial clock. All three pins are brought into the system clock domain through two-flop synchronizers, and the serial clock edges are found by comparing successive synchronized samples. When the 24th bit of a frame has arrived, the block hands the whole word to the command decoder. The upper byte of the word is the control field and the lower 16 bits are the data field. The hand-off is a single-cycle valid pulse, and the word stays held until the next pulse.

Only the first 24 bits after select falls belong to this device. If select is released earlier, the partial frame is thrown away. Bits that follow the 24th are ignored for as long as select stays low. Once the frame is complete, an active-low ready output drops and serves as the select of the next device in a chain. The devices share the serial clock and data lines, so each device takes its own 24-bit slice of one long stream. The decoder can switch the ready output off through a configuration strobe. The enable comes up set, so a chain works straight after reset.

Top module: `dcs_frame_rx`

## Requirements
- R1: After reset `frame_vld` is 0, `frame_word` is 0, `ready_n_out` is 1, and the ready enable is set, so the first completed frame drives `ready_n_out` low.
- R2: While `sel_n_in` is low, `sdi_in` is sampled on each falling edge of `sclk_in`. The first sampled bit lands in `frame_word[23]` and the 24th in `frame_word[0]`, so bits [23:16] carry the control byte and bits [15:0] carry the data.
- R3: Each frame of at least 24 bits produces exactly one `frame_vld` pulse, one system clock wide, no more than 5 system clocks after the 24th falling edge. `frame_word` does not change between pulses.
- R4: If `sel_n_in` rises after fewer than 24 falling edges, no pulse is produced and `frame_word` keeps its value. The next frame is built from its own bits only.
- R5: Falling edges after the 24th, while select stays low, produce no further pulse and leave `frame_word` unchanged.
- R6: With the enable set, `ready_n_out` stays high until the frame completes and goes low in the cycle of the `frame_vld` pulse. It returns high within 4 system clocks after `sel_n_in` rises.
- R7: A cycle with `cfg_wr` high loads the ready enable from `cfg_ready_en`. While the enable is 0, `ready_n_out` stays high but frames are still delivered. Writing 1 restores the normal behaviour.
- R8: The level of `sclk_in` while `sel_n_in` is high does not matter. Clock edges seen while deselected are not counted, so frames started with the clock idling high or idling low decode the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n_in | input | 1 | Asynchronous active-low frame select from host or upstream device |
| sclk_in | input | 1 | Asynchronous serial clock, data taken on falling edges |
| sdi_in | input | 1 | Asynchronous serial data, MSB first |
| cfg_wr | input | 1 | One-cycle strobe from the decoder that loads the ready enable |
| cfg_ready_en | input | 1 | New value for the ready enable |
| frame_vld | output | 1 | One-cycle pulse: a complete frame is in `frame_word` |
| frame_word | output | 24 | Last completed frame, control byte in [23:16] |
| ready_n_out | output | 1 | Active-low select for the next device in the chain |

## Verification
A walking single one across all 24 bit positions shows the bit order and reveals any stuck or swapped lane. A set of arithmetic word patterns (all zeros, all ones, alternating values and a generated sequence) covers mixed content. Short frames of every length from 0 to 23 bits, each followed by a full frame of a different word, show that partial frames are dropped and that no leftover bits leak into the next frame. Frames of 25 to 48 bits show that the tail is ignored and that the ready handoff happens at the right time. The idle clock level alternates between frames, and a pass with the ready enable cleared separates enable gating from frame delivery.

// File: rtl/dcs_rx_pkg.sv
// Package: shared lane indices and helpers for the serial frame receiver.
// Assumes: three asynchronous input lanes are grouped into one vector.
package dcs_rx_pkg;
    localparam int LANE_SEL  = 0;
    localparam int LANE_CLK  = 1;
    localparam int LANE_DAT  = 2;
    localparam int NUM_LANES = 3;

    // Reset level per lane: select idles high, clock and data low.
    localparam logic [NUM_LANES-1:0] LANE_RST = 3'b001;

    // Width needed to count 0..n-1.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/dcs_rx_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes: each lane is independent; STAGES >= 2; reset value per lane given.
module dcs_rx_sync #(
    parameter int                 STAGES  = 2,
    parameter int                 WIDTH   = 3,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage: capture the raw asynchronous levels.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[0] <= RST_VAL;
                else        pipe[0] <= raw_in;
            end
        end else begin : g_next
            // Later stages: let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= RST_VAL;
                else        pipe[s] <= pipe[s-1];
            end
        end
    end

    assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/dcs_rx_shift.sv
// Module: frame assembler. Detects serial clock falling edges and shifts
//         data MSB first. Emits one strobe on the last bit of a frame and
//         then ignores the rest until select is released.
// Assumes: all inputs are already synchronous to clk.
module dcs_rx_shift #(
    parameter int FRAME_BITS = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_s,
    input  logic                  sclk_s,
    input  logic                  sdi_s,
    output logic                  word_vld,
    output logic [FRAME_BITS-1:0] word,
    output logic                  frame_done
);
    import dcs_rx_pkg::*;

    localparam int               CNT_W = cnt_width(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_BITS - 1);

    logic                  sclk_d;
    logic                  fall;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic [FRAME_BITS-1:0] next_word;

    assign fall      = sclk_d & ~sclk_s;
    assign next_word = {shreg[FRAME_BITS-2:0], sdi_s};

    // Delayed clock sample used for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // Bit counting, shifting, completion flag and the hand-off strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            frame_done <= 1'b0;
            word_vld   <= 1'b0;
            word       <= '0;
        end else begin
            word_vld <= 1'b0;
            if (sel_s) begin
                bit_cnt    <= '0;
                frame_done <= 1'b0;
            end else if (fall && !frame_done) begin
                shreg <= next_word;
                if (bit_cnt == LAST) begin
                    frame_done <= 1'b1;
                    word_vld   <= 1'b1;
                    word       <= next_word;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dcs_rx_ready.sv
// Module: ready handoff. Holds the enable bit and drives the active-low
//         select for the next device once the local frame is complete.
// Assumes: frame_done is high from frame completion until select release.
module dcs_rx_ready (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_ready_en,
    input  logic frame_done,
    output logic ready_n
);
    logic en_q;

    // Enable register, loaded by the decoder, set out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b1;
        else if (cfg_wr) en_q <= cfg_ready_en;
    end

    assign ready_n = ~(frame_done & en_q);
endmodule

// File: rtl/dcs_frame_rx.sv
// Module: daisy-chainable 24-bit serial command frame receiver (top).
// Assumes: sel_n_in, sclk_in and sdi_in are asynchronous. The serial clock
//          is slow enough for edge detection (each level lasts >= 3 clk).
module dcs_frame_rx #(
    parameter int FRAME_BITS  = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_n_in,
    input  logic                  sclk_in,
    input  logic                  sdi_in,
    input  logic                  cfg_wr,
    input  logic                  cfg_ready_en,
    output logic                  frame_vld,
    output logic [FRAME_BITS-1:0] frame_word,
    output logic                  ready_n_out
);
    import dcs_rx_pkg::*;

    logic [NUM_LANES-1:0] raw;
    logic [NUM_LANES-1:0] syn;
    logic                 done;

    assign raw[LANE_SEL] = sel_n_in;
    assign raw[LANE_CLK] = sclk_in;
    assign raw[LANE_DAT] = sdi_in;

    dcs_rx_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (NUM_LANES),
        .RST_VAL (LANE_RST)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (raw),
        .sync_out (syn)
    );

    dcs_rx_shift #(
        .FRAME_BITS (FRAME_BITS)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_s      (syn[LANE_SEL]),
        .sclk_s     (syn[LANE_CLK]),
        .sdi_s      (syn[LANE_DAT]),
        .word_vld   (frame_vld),
        .word       (frame_word),
        .frame_done (done)
    );

    dcs_rx_ready u_ready (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_ready_en (cfg_ready_en),
        .frame_done   (done),
        .ready_n      (ready_n_out)
    );
endmodule

// File: rtl/dcs_frame_rx_chk.sv
// Module: checker for dcs_frame_rx, bound to the top.
// Assumes: select is held high for several clocks between frames.
module dcs_frame_rx_chk #(
    parameter int FRAME_BITS = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sel_n_in,
    input logic                  cfg_wr,
    input logic                  cfg_ready_en,
    input logic                  frame_vld,
    input logic [FRAME_BITS-1:0] frame_word,
    input logic                  ready_n_out
);
    logic [2:0] hi_cnt;
    logic       seen;

    // Count (saturating) how long select has been high at the pin.
    always_ff @(posedge clk) begin
        if (!rst_n)         hi_cnt <= 3'd0;
        else if (!sel_n_in) hi_cnt <= 3'd0;
        else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
    end

    // Remember a strobe inside the current select window.
    always_ff @(posedge clk) begin
        if (!rst_n || hi_cnt >= 3'd4) seen <= 1'b0;
        else if (frame_vld)           seen <= 1'b1;
    end

    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld); // R3
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |-> $stable(frame_word)); // R3
    AST_ONE_STROBE_PER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> !seen); // R5
    AST_READY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt >= 3'd4) |-> ready_n_out); // R6
    AST_READY_FALL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ready_n_out) && !$past(cfg_wr)) |-> frame_vld); // R6
    AST_READY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_ready_en) |=> ready_n_out); // R7
endmodule

bind dcs_frame_rx dcs_frame_rx_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_n_in     (sel_n_in),
    .cfg_wr       (cfg_wr),
    .cfg_ready_en (cfg_ready_en),
    .frame_vld    (frame_vld),
    .frame_word   (frame_word),
    .ready_n_out  (ready_n_out)
);

// File: tb/sim_dcs_frame_rx.sv
// Bench: sweeps frame contents, lengths, idle clock level and ready enable.
module sim_dcs_frame_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_en = 1'b0;
    logic        frame_vld;
    logic [23:0] frame_word;
    logic        ready_n_out;

    int          n_chk = 0;
    int          n_bad = 0;
    int          nstb = 0;
    logic        prev_vld = 1'b0;
    logic [23:0] exp_word = 24'h0;
    bit          en_exp = 1'b1;
    logic        rdy_end;

    always #10 clk = ~clk;

    dcs_frame_rx u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_n_in     (sel_n),
        .sclk_in      (sclk),
        .sdi_in       (sdi),
        .cfg_wr       (cfg_wr),
        .cfg_ready_en (cfg_en),
        .frame_vld    (frame_vld),
        .frame_word   (frame_word),
        .ready_n_out  (ready_n_out)
    );

    task automatic chk(input bit ok, input string req, input logic [47:0] act,
                       input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Strobe monitor: counts pulses and checks their width (R3).
    always @(negedge clk) begin
        if (rst_n && frame_vld) begin
            nstb++;
            chk(!prev_vld, "R3 strobe width", 48'(prev_vld), 48'd0);
        end
        prev_vld = frame_vld;
    end

    // Send the top n bits of v as one frame; idle_hi sets the idle clock level.
    task automatic xfer(input logic [47:0] v, input int n, input bit idle_hi);
        int   s0;
        logic mid_rdy;
        int   mid_cnt;
        mid_rdy = 1'b1;
        mid_cnt = 0;
        s0 = nstb;
        sclk = idle_hi;
        tick(6);
        sel_n = 1'b0;
        tick(6);
        mid_cnt = s0;
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1;
            sdi = v[47-i];
            tick(4);
            sclk = 1'b0;
            tick(4);
            if (i == 22) begin
                mid_rdy = ready_n_out;
                mid_cnt = nstb;
            end
            if (i == 23)
                chk(nstb == s0 + 1, "R3 strobe within 5 clocks", 48'(nstb - s0), 48'd1);
        end
        tick(8);
        rdy_end = ready_n_out;
        if (n >= 24) begin
            exp_word = v[47:24];
            chk(nstb == s0 + 1, "R3 one strobe per frame", 48'(nstb - s0), 48'd1);
            chk(frame_word == exp_word, "R2 word content", 48'(frame_word), 48'(exp_word));
            chk(mid_rdy == 1'b1 && mid_cnt == s0, "R6 ready high before last bit",
                48'(mid_rdy), 48'd1);
            if (en_exp)
                chk(ready_n_out == 1'b0, "R6 ready low after frame", 48'(ready_n_out), 48'd0);
            else
                chk(ready_n_out == 1'b1, "R7 ready held high when disabled",
                    48'(ready_n_out), 48'd1);
            if (n > 24)
                chk(frame_word == v[47:24] && nstb == s0 + 1, "R5 tail ignored",
                    48'(frame_word), 48'(v[47:24]));
        end else begin
            chk(nstb == s0, "R4 short frame no strobe", 48'(nstb - s0), 48'd0);
            chk(frame_word == exp_word, "R4 word kept", 48'(frame_word), 48'(exp_word));
            chk(ready_n_out == 1'b1, "R4 ready high", 48'(ready_n_out), 48'd1);
        end
        sel_n = 1'b1;
        sdi = 1'b0;
        tick(4);
        chk(ready_n_out == 1'b1, "R6 ready released", 48'(ready_n_out), 48'd1);
        tick(2);
    endtask

    task automatic set_en(input bit e);
        cfg_en = e;
        cfg_wr = 1'b1;
        tick(1);
        cfg_wr = 1'b0;
        cfg_en = 1'b0;
        tick(1);
        en_exp = e;
    endtask

    initial begin
        logic [23:0] w;
        tick(5);
        rst_n = 1'b1;
        tick(1);
        chk(frame_vld == 1'b0, "R1 reset strobe", 48'(frame_vld), 48'd0);
        chk(frame_word == 24'h0, "R1 reset word", 48'(frame_word), 48'd0);
        chk(ready_n_out == 1'b1, "R1 reset ready", 48'(ready_n_out), 48'd1);

        // First frame: enable must already be set out of reset (R1).
        xfer({24'hC3_5A0F, 24'h0}, 24, 1'b0);
        chk(rdy_end == 1'b0, "R1 ready enable set after reset", 48'(rdy_end), 48'd0);

        // Walking one over all positions, idle level alternating (R2, R8).
        for (int k = 0; k < 24; k++) begin
            w = 24'h800000 >> k;
            xfer({w, 24'h0}, 24, k[0]);
        end

        // Arithmetic patterns (R2).
        xfer({24'h000000, 24'h0}, 24, 1'b1);
        xfer({24'hFFFFFF, 24'h0}, 24, 1'b0);
        xfer({24'hA5A5A5, 24'h0}, 24, 1'b1);
        xfer({24'h5A5A5A, 24'h0}, 24, 1'b0);
        for (int j = 0; j < 12; j++) begin
            w = 24'(j * 24'h0F1E2D + 24'h00C3A5);
            xfer({w, 24'h0}, 24, j[1]);
        end

        // Every short length, each followed by a full frame (R4, R8).
        for (int n = 0; n < 24; n++) begin
            xfer({24'hFFFFFF, 24'hFFFFFF}, n, n[0]);
            w = 24'(n * 24'h010203);
            xfer({w, 24'h0}, 24, ~n[0]);
        end

        // Long frames: tail must be ignored (R5).
        for (int n = 25; n <= 48; n++) begin
            w = 24'(n * 24'h0A0B0C);
            xfer({w, ~w}, n, n[0]);
        end

        // Ready enable cleared, then restored (R7).
        set_en(1'b0);
        xfer({24'h13579B, 24'h0}, 24, 1'b0);
        xfer({24'h2468AC, 24'hFFFFFF}, 30, 1'b1);
        set_en(1'b1);
        xfer({24'hFEDCBA, 24'h0}, 24, 1'b0);
        chk(rdy_end == 1'b0, "R7 ready restored", 48'(rdy_end), 48'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R3 watchdog act=%h exp=%h", 48'd1, 48'd0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule